// File: doc/BRIEF.md
# Processor Bus Bridge

This block sits between an asynchronous, byte-wide external processor bus and a set of peripherals that run on the FPGA clock. The processor drives an active-low chip select, an active-low write strobe, a read/write direction line, an address and write data. The bridge brings these into the FPGA clock domain. It decodes the upper address bits into one-hot selects for up to four internal peripherals, and it turns each write strobe into exactly one single-cycle write pulse. On reads it returns the read data of the addressed peripheral.

The bidirectional data pins are modelled as three ports: pin data in, pin data out and a pin output enable. The only tri-state buffer therefore sits in the pad ring. Inside the block each peripheral has its own write-data bus and its own read-data bus, and an AND-OR multiplexer combines the read buses. A parameter selects whether the output enable comes straight from the pins or from the synchronised control lines.

Top module: `pb_bridge`

## Requirements
- R1: After reset, with `bus_cs_n` high, `per_sel` is 0, `per_wr` is 0 and `bus_oe` is 0.
- R2: In the default mode, `bus_oe` is 1 exactly when `bus_cs_n` is 0 (selected) and `bus_rdwr_n` is 1 (read). It is 0 during writes and while the device is not selected.
- R3: Each low period of `bus_we_n` yields exactly one `per_wr` pulse one clock long, no matter how many clocks the strobe stays low.
- R4: A fall of `bus_we_n` produces no pulse, and leaves `per_wdata` unchanged, when `bus_cs_n` is high or `bus_rdwr_n` is high.
- R5: `per_sel` is one-hot with bit k set, where k = `bus_addr[7:6]`, while the device is selected. It is all zero otherwise.
- R6: While `per_wr` is high, `per_addr` and `per_wdata` hold the address and data that were on the pins when the strobe fell.
- R7: `bus_dout` equals byte k of `per_rdata` (bits 8k+7..8k) when `per_sel` bit k is set, and 0x00 when `per_sel` is zero.
- R8: Control inputs pass through two flip-flop stages and one register. If `bus_cs_n` falls between two clock edges, `per_sel` is still zero after the second rising edge that follows and is set after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FPGA clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | External chip select, active low, asynchronous |
| bus_we_n | input | 1 | External write strobe, active low, asynchronous |
| bus_rdwr_n | input | 1 | Direction line, 1 = read, 0 = write |
| bus_addr | input | 8 | External address |
| bus_din | input | 8 | Data from the pins (write data) |
| bus_dout | output | 8 | Data to the pins (read data) |
| bus_oe | output | 1 | Pin output enable, 1 drives the pins |
| per_sel | output | 4 | One-hot peripheral select |
| per_wr | output | 1 | Single-cycle write pulse |
| per_addr | output | 8 | Registered address for the peripherals |
| per_wdata | output | 8 | Registered write data for the peripherals |
| per_rdata | input | 32 | Concatenated read data, byte k from peripheral k |

## Verification
The assertions rely on the processor keeping the address, data and direction lines steady for as long as the chip select is low. They also assume each strobe level holds for more than one FPGA clock. The bench meets both conditions. It sets address, data and direction at a falling clock edge before it lowers the chip select, and it holds every strobe low for at least three clocks. It then waits several clocks after releasing the strobe and again after releasing the chip select. Every address is written with a strobe length that varies from one access to the next, and every address is read back.

// File: rtl/pb_bridge_pkg.sv
package pb_bridge_pkg;

   localparam int PB_MIN_STAGES = 2;

   typedef struct packed {
      logic cs_n;
      logic we_n;
      logic rdwr_n;
   } pb_ctl_t;

   localparam pb_ctl_t PB_CTL_IDLE = '{cs_n: 1'b1, we_n: 1'b1, rdwr_n: 1'b1};

endpackage

// File: rtl/pb_sync.sv
module pb_sync #(
   parameter int               WIDTH     = 1,
   parameter int               STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < pb_bridge_pkg::PB_MIN_STAGES) begin : g_bad_stages
      $error("pb_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= RESET_VAL;
      end else begin
         chain_q[0] <= d;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/pb_strobe.sv
module pb_strobe #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s_n,
   input  logic              we_s_n,
   input  logic              rdwr_s_n,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              cs_act,
   output logic [ADDR_W-1:0] addr_out,
   output logic [DATA_W-1:0] data_out,
   output logic              wr_pulse
);

   logic we_prev_q;
   logic strobe_fall;

   // synchronised strobe edge, qualified by select and write direction
   assign strobe_fall = we_prev_q & ~we_s_n & ~cs_s_n & ~rdwr_s_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_prev_q <= 1'b1;
         cs_act    <= 1'b0;
         addr_out  <= '0;
         data_out  <= '0;
         wr_pulse  <= 1'b0;
      end else begin
         we_prev_q <= we_s_n;
         cs_act    <= ~cs_s_n;
         wr_pulse  <= strobe_fall;
         if (~cs_s_n && (we_s_n || strobe_fall)) addr_out <= addr_in;
         if (strobe_fall) data_out <= data_in;
      end
   end

   // R3: a pulse never lasts two cycles
   p_pulse_single_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |=> !wr_pulse);

   // R4: a pulse only occurs while the select register is active
   p_pulse_needs_cs_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |-> cs_act);

   // R6: write data stays put in the cycle after a pulse
   p_wdata_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |=> $stable(data_out));

endmodule

// File: rtl/pb_decode.sv
module pb_decode #(
   parameter int NUM_PERIPH = 4,
   localparam int SEL_W     = $clog2(NUM_PERIPH)
) (
   input  logic                  cs_act,
   input  logic [SEL_W-1:0]      field,
   output logic [NUM_PERIPH-1:0] sel
);

   always_comb begin
      sel = '0;
      for (int i = 0; i < NUM_PERIPH; i++) begin
         if (cs_act && (field == SEL_W'(i))) sel[i] = 1'b1;
      end
   end

endmodule

// File: rtl/pb_rdmux.sv
module pb_rdmux #(
   parameter int DATA_W     = 8,
   parameter int NUM_PERIPH = 4
) (
   input  logic [NUM_PERIPH-1:0]        sel,
   input  logic [NUM_PERIPH*DATA_W-1:0] rdata,
   output logic [DATA_W-1:0]            dout
);

   logic [DATA_W-1:0] gated [NUM_PERIPH];

   for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_gate
      assign gated[i] = {DATA_W{sel[i]}} & rdata[i*DATA_W +: DATA_W];
   end

   always_comb begin
      dout = '0;
      for (int i = 0; i < NUM_PERIPH; i++) dout = dout | gated[i];
   end

endmodule

// File: rtl/pb_bridge.sv
module pb_bridge #(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 8,
   parameter int NUM_PERIPH   = 4,
   parameter int SYNC_STAGES  = 2,
   parameter bit OE_FROM_SYNC = 1'b0,
   localparam int SEL_W       = $clog2(NUM_PERIPH),
   localparam int RD_W        = NUM_PERIPH * DATA_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_cs_n,
   input  logic                  bus_we_n,
   input  logic                  bus_rdwr_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_din,
   output logic [DATA_W-1:0]     bus_dout,
   output logic                  bus_oe,
   output logic [NUM_PERIPH-1:0] per_sel,
   output logic                  per_wr,
   output logic [ADDR_W-1:0]     per_addr,
   output logic [DATA_W-1:0]     per_wdata,
   input  logic [RD_W-1:0]       per_rdata
);
   import pb_bridge_pkg::*;

   if (NUM_PERIPH < 2) begin : g_bad_count
      $error("pb_bridge: NUM_PERIPH must be at least 2");
   end
   if (SEL_W > ADDR_W) begin : g_bad_addr
      $error("pb_bridge: address too narrow for peripheral count");
   end

   pb_ctl_t ctl_raw, ctl_s;
   logic    cs_act;

   assign ctl_raw = '{cs_n: bus_cs_n, we_n: bus_we_n, rdwr_n: bus_rdwr_n};

   pb_sync #(
      .WIDTH    ($bits(pb_ctl_t)),
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(PB_CTL_IDLE)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (ctl_raw),
      .q    (ctl_s)
   );

   pb_strobe #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_strobe (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_s_n  (ctl_s.cs_n),
      .we_s_n  (ctl_s.we_n),
      .rdwr_s_n(ctl_s.rdwr_n),
      .addr_in (bus_addr),
      .data_in (bus_din),
      .cs_act  (cs_act),
      .addr_out(per_addr),
      .data_out(per_wdata),
      .wr_pulse(per_wr)
   );

   pb_decode #(
      .NUM_PERIPH(NUM_PERIPH)
   ) u_decode (
      .cs_act(cs_act),
      .field (per_addr[ADDR_W-1 -: SEL_W]),
      .sel   (per_sel)
   );

   // R5: never more than one peripheral selected
   p_sel_onehot_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(per_sel));

   // R5: selection only while the select register is active
   p_sel_needs_cs_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (per_sel != '0) |-> cs_act);

   pb_rdmux #(
      .DATA_W    (DATA_W),
      .NUM_PERIPH(NUM_PERIPH)
   ) u_rdmux (
      .sel  (per_sel),
      .rdata(per_rdata),
      .dout (bus_dout)
   );

   // R7: idle read path returns zero
   p_dout_zero_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (per_sel == '0) |-> (bus_dout == '0));

   if (OE_FROM_SYNC) begin : g_oe_sync
      assign bus_oe = ctl_s.rdwr_n & ~ctl_s.cs_n;
   end else begin : g_oe_pins
      assign bus_oe = ~(~bus_rdwr_n | bus_cs_n);
   end

   // R2: pins never driven in the same cycle as a write pulse taken under a write direction
   p_oe_not_with_write_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (per_wr && !bus_rdwr_n) |-> !bus_oe);

endmodule

// File: tb/pb_bridge_tb.sv
module pb_bridge_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_cs_n = 1'b1;
   logic        bus_we_n = 1'b1;
   logic        bus_rdwr_n = 1'b1;
   logic [7:0]  bus_addr = '0;
   logic [7:0]  bus_din = '0;
   logic [7:0]  bus_dout;
   logic        bus_oe;
   logic [3:0]  per_sel;
   logic        per_wr;
   logic [7:0]  per_addr;
   logic [7:0]  per_wdata;
   logic [31:0] per_rdata;

   int n_checks = 0;
   int n_fail   = 0;
   int pulse_cnt = 0;
   logic [7:0] cap_addr, cap_data;
   logic [3:0] cap_sel;

   always #2 clk = ~clk;

   pb_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n),
      .bus_rdwr_n(bus_rdwr_n), .bus_addr(bus_addr), .bus_din(bus_din),
      .bus_dout(bus_dout), .bus_oe(bus_oe), .per_sel(per_sel), .per_wr(per_wr),
      .per_addr(per_addr), .per_wdata(per_wdata), .per_rdata(per_rdata)
   );

   // peripheral models: byte k = low six address bits plus 16*(k+1)
   always_comb begin
      for (int k = 0; k < 4; k++)
         per_rdata[k*8 +: 8] = {2'b00, per_addr[5:0]} + 8'(16 * (k + 1));
   end

   always @(negedge clk) begin
      if (per_wr) begin
         pulse_cnt = pulse_cnt + 1;
         cap_addr  = per_addr;
         cap_data  = per_wdata;
         cap_sel   = per_sel;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_write(input logic [7:0] a, input logic [7:0] d, input int hold);
      bus_addr = a; bus_din = d; bus_rdwr_n = 1'b0; bus_cs_n = 1'b0;
      #1 chk(bus_oe == 1'b0, "R2 oe during write", bus_oe, 0);
      cyc(1);
      pulse_cnt = 0;
      bus_we_n = 1'b0;
      cyc(hold);
      bus_we_n = 1'b1;
      cyc(5);
      chk(pulse_cnt == 1, "R3 pulse count", pulse_cnt, 1);
      chk(cap_addr == a, "R6 per_addr", cap_addr, a);
      chk(cap_data == d, "R6 per_wdata", cap_data, d);
      chk(cap_sel == (4'b0001 << a[7:6]), "R5 sel at write", cap_sel, 4'b0001 << a[7:6]);
      bus_cs_n = 1'b1; bus_rdwr_n = 1'b1;
      cyc(4);
   endtask

   task automatic do_read(input logic [7:0] a);
      logic [7:0] exp;
      exp = {2'b00, a[5:0]} + 8'(16 * (a[7:6] + 1));
      bus_addr = a; bus_rdwr_n = 1'b1; bus_cs_n = 1'b0;
      #1 chk(bus_oe == 1'b1, "R2 oe on read", bus_oe, 1);
      cyc(5);
      chk(bus_dout == exp, "R7 read data", bus_dout, exp);
      chk(per_sel == (4'b0001 << a[7:6]), "R5 sel on read", per_sel, 4'b0001 << a[7:6]);
      bus_cs_n = 1'b1;
      #1 chk(bus_oe == 1'b0, "R2 oe idle", bus_oe, 0);
      cyc(5);
      chk(per_sel == 4'b0000, "R5 sel cleared", per_sel, 0);
      chk(bus_dout == 8'h00, "R7 dout zero", bus_dout, 0);
   endtask

   initial begin
      cyc(3);
      chk(per_sel == 0 && per_wr == 0 && bus_oe == 0, "R1 reset outputs",
          {per_sel, per_wr, bus_oe}, 0);
      rst_n = 1'b1;
      cyc(3);
      chk(per_sel == 0 && per_wr == 0 && bus_oe == 0, "R1 after release",
          {per_sel, per_wr, bus_oe}, 0);

      // R8: select latency through the synchronisers
      bus_addr = 8'h80; bus_rdwr_n = 1'b1; bus_cs_n = 1'b0;
      cyc(1);
      chk(per_sel == 0, "R8 sel after edge 1", per_sel, 0);
      cyc(1);
      chk(per_sel == 0, "R8 sel after edge 2", per_sel, 0);
      cyc(1);
      chk(per_sel == 4'b0100, "R8 sel after edge 3", per_sel, 4'b0100);
      bus_cs_n = 1'b1;
      cyc(5);

      for (int a = 0; a < 256; a++)
         do_write(8'(a), 8'(a * 7 + 3), 3 + (a % 6));
      for (int a = 0; a < 256; a++)
         do_read(8'(a));

      // R4: strobe while not selected
      pulse_cnt = 0;
      bus_din = 8'h5A; bus_rdwr_n = 1'b0; bus_cs_n = 1'b1;
      cyc(1); bus_we_n = 1'b0; cyc(5); bus_we_n = 1'b1; cyc(5);
      chk(pulse_cnt == 0, "R4 no pulse when deselected", pulse_cnt, 0);
      chk(per_wdata == 8'(255 * 7 + 3), "R4 wdata kept, deselected", per_wdata, 8'(255 * 7 + 3));

      // R4: strobe while selected in read direction
      bus_rdwr_n = 1'b1; bus_cs_n = 1'b0;
      cyc(1); bus_we_n = 1'b0; cyc(5); bus_we_n = 1'b1; cyc(5);
      chk(pulse_cnt == 0, "R4 no pulse in read direction", pulse_cnt, 0);
      chk(per_wdata == 8'(255 * 7 + 3), "R4 wdata kept, read dir", per_wdata, 8'(255 * 7 + 3));
      bus_cs_n = 1'b1;
      cyc(5);

      // R3: very long strobe
      do_write(8'hC5, 8'hE1, 40);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule